// File: doc/BRIEF.md
# Binary and Packed-Decimal Add/Subtract Unit

This block performs 8-bit addition with carry and subtraction with borrow. It runs either in plain binary or, when a decimal-mode input is high, on two packed BCD digits with automatic decimal correction. Subtraction treats the carry as an inverted borrow. A carry of 1 going in means "no borrow pending", and a carry of 1 coming out means no borrow occurred.

A routing-mode input chooses where the first operand comes from and where the result goes. With the mode low, the first operand is the accumulator and the result is meant for the accumulator. With the mode high, the first operand is the memory byte that index register X points at, and the result is meant for that same memory byte.

The caller supplies both candidate first operands and the second operand. The block returns the result, a destination select and the carry, overflow, zero and negative outputs. All of these are registered, so they appear one clock after an operation is presented.

Top module: `bcd_addsub_unit`

## Requirements
- R1: One clock after a cycle with `op_valid` high, `res_valid` is high and carries that operation's result. After a cycle with `op_valid` low, `res_valid` is low. While `rst_n` is low, every output is 0.
- R2: While `op_valid` is low, `res_data`, `res_to_mem`, `carry_out`, `ovf_out`, `zero_out` and `neg_out` keep their previous values, whatever the other inputs do.
- R3: In binary mode (`dec_mode`=0) with `op_sub`=0, {`carry_out`,`res_data`} equals P + Q + `carry_in`. Here P is the routed first operand and Q is `opnd_in`.
- R4: In binary mode with `op_sub`=1, `res_data` = (P − Q − (1 − `carry_in`)) mod 256. `carry_out` is 1 exactly when that difference is not negative, that is, when no borrow occurred.
- R5: In binary mode, `ovf_out` is 1 exactly when the true signed (two's complement) result lies outside −128..+127. An addition of operands with different sign bits never sets it.
- R6: In binary mode, `zero_out` is 1 exactly when `res_data` is 0x00, and `neg_out` equals bit 7 of `res_data`.
- R7: In decimal mode (`dec_mode`=1) with `op_sub`=0 and both operands valid packed BCD (each nibble 0..9, high nibble = tens), `res_data` is the BCD encoding of (P + Q + `carry_in`) mod 100. `carry_out` = 1 exactly when that sum is 100 or more.
- R8: In decimal mode with `op_sub`=1 and valid BCD operands, `res_data` is the BCD encoding of (P − Q − (1 − `carry_in`)) mod 100. `carry_out` = 1 exactly when no borrow occurred. In decimal mode `ovf_out`, `zero_out` and `neg_out` carry no defined meaning.
- R9: With `tmode`=0, P is `acc_in`, `xmem_in` has no effect, and `res_to_mem` is 0 (result goes to the accumulator). With `tmode`=1, P is `xmem_in`, `acc_in` has no effect, and `res_to_mem` is 1 (result goes to the byte addressed by X).
- R10: No decimal correction is applied when `dec_mode` is 0. For example, 0x09 + 0x01 with carry in 0 gives 0x0A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sub | input | 1 | 1 = subtract with borrow, 0 = add with carry |
| dec_mode | input | 1 | 1 = packed-BCD arithmetic, 0 = binary |
| tmode | input | 1 | Routing: 1 = first operand and destination is memory at X |
| acc_in | input | 8 | Accumulator value |
| xmem_in | input | 8 | Byte at the address held in index register X |
| opnd_in | input | 8 | Second operand |
| carry_in | input | 1 | Carry in (inverted borrow on subtraction) |
| res_valid | output | 1 | Result outputs hold a new result |
| res_data | output | 8 | Result byte |
| res_to_mem | output | 1 | Destination: 1 = memory at X, 0 = accumulator |
| carry_out | output | 1 | Carry out / not-borrow |
| ovf_out | output | 1 | Signed overflow |
| zero_out | output | 1 | Result is zero |
| neg_out | output | 1 | Result bit 7 |

## Verification
The result sits in one register stage, so any fault in the operand routing, the carry chain or the digit correction shows up at the ports one clock after the offending operation. The bench compares every operation against a model built from decimal and integer arithmetic. A wrong correction step in one digit cell yields a wrong digit or carry on that same result. That is why all valid BCD operand pairs are swept for both carries and both directions. A stuck routing or hold register shows as a wrong destination or a changed output during idle cycles on the very next sample.

// File: rtl/bcd_addsub_pkg.sv
package bcd_addsub_pkg;

    typedef enum logic {
        DEST_ACC  = 1'b0,
        DEST_XMEM = 1'b1
    } dest_e;

    localparam int DIGIT_W = 4;

endpackage

// File: rtl/bcd_operand_route.sv
module bcd_operand_route
    import bcd_addsub_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              tmode,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] xmem_in,
    output logic [DATA_W-1:0] first_op,
    output dest_e             dest
);

    always_comb begin
        if (tmode) begin
            first_op = xmem_in;
            dest     = DEST_XMEM;
        end else begin
            first_op = acc_in;
            dest     = DEST_ACC;
        end
    end

endmodule

// File: rtl/bcd_binary_core.sv
module bcd_binary_core #(
    parameter int DATA_W = 8
) (
    input  logic              sub,
    input  logic [DATA_W-1:0] p,
    input  logic [DATA_W-1:0] q,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              ovf
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] q_eff;
    logic [DATA_W:0]   wide;

    always_comb begin
        // subtraction adds the complement; carry acts as not-borrow
        q_eff = sub ? ~q : q;
        wide  = {1'b0, p} + {1'b0, q_eff} + {{DATA_W{1'b0}}, cin};
        sum   = wide[DATA_W-1:0];
        cout  = wide[DATA_W];
        ovf   = (p[MSB] == q_eff[MSB]) && (sum[MSB] != p[MSB]);
    end

endmodule

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
    import bcd_addsub_pkg::*;
(
    input  logic               sub,
    input  logic [DIGIT_W-1:0] a,
    input  logic [DIGIT_W-1:0] b,
    input  logic               cin,
    output logic [DIGIT_W-1:0] d,
    output logic               cout
);

    logic [DIGIT_W:0] raw;

    always_comb begin
        if (!sub) begin
            raw = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
            if (raw > 5'd9) begin
                d    = raw[DIGIT_W-1:0] + 4'd6;
                cout = 1'b1;
            end else begin
                d    = raw[DIGIT_W-1:0];
                cout = 1'b0;
            end
        end else begin
            raw = {1'b0, a} - {1'b0, b} - {{DIGIT_W{1'b0}}, ~cin};
            if (raw[DIGIT_W]) begin
                d    = raw[DIGIT_W-1:0] - 4'd6;
                cout = 1'b0;
            end else begin
                d    = raw[DIGIT_W-1:0];
                cout = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bcd_decimal_chain.sv
module bcd_decimal_chain
    import bcd_addsub_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              sub,
    input  logic [DATA_W-1:0] p,
    input  logic [DATA_W-1:0] q,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout
);

    // DATA_W is expected to be a whole number of digits
    localparam int NDIG = DATA_W / DIGIT_W;

    logic [NDIG:0] cy;

    assign cy[0] = cin;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        bcd_digit_cell u_cell (
            .sub  (sub),
            .a    (p[g*DIGIT_W +: DIGIT_W]),
            .b    (q[g*DIGIT_W +: DIGIT_W]),
            .cin  (cy[g]),
            .d    (sum[g*DIGIT_W +: DIGIT_W]),
            .cout (cy[g+1])
        );
    end

    assign cout = cy[NDIG];

endmodule

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit
    import bcd_addsub_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_sub,
    input  logic              dec_mode,
    input  logic              tmode,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] xmem_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic              carry_in,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              res_to_mem,
    output logic              carry_out,
    output logic              ovf_out,
    output logic              zero_out,
    output logic              neg_out
);

    localparam int MSB = DATA_W - 1;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        dest_e             dest;
        logic              c;
        logic              v;
        logic              z;
        logic              n;
    } res_t;

    res_t              st_d, st_q;
    logic [DATA_W-1:0] first_op;
    dest_e             dest_sel;
    logic [DATA_W-1:0] bin_sum, dec_sum;
    logic              bin_c, bin_v, dec_c;

    bcd_operand_route #(.DATA_W(DATA_W)) u_route (
        .tmode    (tmode),
        .acc_in   (acc_in),
        .xmem_in  (xmem_in),
        .first_op (first_op),
        .dest     (dest_sel)
    );

    bcd_binary_core #(.DATA_W(DATA_W)) u_bin (
        .sub  (op_sub),
        .p    (first_op),
        .q    (opnd_in),
        .cin  (carry_in),
        .sum  (bin_sum),
        .cout (bin_c),
        .ovf  (bin_v)
    );

    bcd_decimal_chain #(.DATA_W(DATA_W)) u_dec (
        .sub  (op_sub),
        .p    (first_op),
        .q    (opnd_in),
        .cin  (carry_in),
        .sum  (dec_sum),
        .cout (dec_c)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = op_valid;
        if (op_valid) begin
            st_d.data = dec_mode ? dec_sum : bin_sum;
            st_d.c    = dec_mode ? dec_c : bin_c;
            // flags below are only meaningful in binary mode
            st_d.v    = bin_v;
            st_d.z    = (st_d.data == '0);
            st_d.n    = st_d.data[MSB];
            st_d.dest = dest_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid  = st_q.valid;
    assign res_data   = st_q.data;
    assign res_to_mem = (st_q.dest == DEST_XMEM);
    assign carry_out  = st_q.c;
    assign ovf_out    = st_q.v;
    assign zero_out   = st_q.z;
    assign neg_out    = st_q.n;

endmodule

// File: rtl/bcd_addsub_unit_chk.sv
module bcd_addsub_unit_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_sub,
    input logic              dec_mode,
    input logic              tmode,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] xmem_in,
    input logic [DATA_W-1:0] opnd_in,
    input logic              carry_in,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic              res_to_mem,
    input logic              carry_out,
    input logic              ovf_out,
    input logic              zero_out,
    input logic              neg_out
);

    localparam int MSB = DATA_W - 1;

    function automatic logic is_bcd(input logic [DATA_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DATA_W / 4; i++) begin
            if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    logic [DATA_W-1:0] p_w;
    logic [DATA_W:0]   add_w;

    assign p_w   = tmode ? xmem_in : acc_in;
    assign add_w = {1'b0, p_w} + {1'b0, opnd_in} + {{DATA_W{1'b0}}, carry_in};

    // R1
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    // R1
    a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);

    // R2
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(res_data) && $stable(carry_out) && $stable(ovf_out)
                       && $stable(res_to_mem) && $stable(zero_out) && $stable(neg_out)));

    // R9
    a_r9_dest: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (res_to_mem == $past(tmode)));

    // R3
    a_r3_bin_add: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !dec_mode && !op_sub) |=> ({carry_out, res_data} == $past(add_w)));

    // R5
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !dec_mode && !op_sub && (p_w[MSB] != opnd_in[MSB])) |=> !ovf_out);

    // R7 R8
    a_r7_bcd_digits: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && dec_mode && is_bcd(p_w) && is_bcd(opnd_in)) |=> is_bcd(res_data));

endmodule

bind bcd_addsub_unit bcd_addsub_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_sub     (op_sub),
    .dec_mode   (dec_mode),
    .tmode      (tmode),
    .acc_in     (acc_in),
    .xmem_in    (xmem_in),
    .opnd_in    (opnd_in),
    .carry_in   (carry_in),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .res_to_mem (res_to_mem),
    .carry_out  (carry_out),
    .ovf_out    (ovf_out),
    .zero_out   (zero_out),
    .neg_out    (neg_out)
);

// File: tb/bcd_addsub_unit_bench.sv
module bcd_addsub_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0, op_sub = 1'b0, dec_mode = 1'b0, tmode = 1'b0;
    logic [7:0] acc_in = '0, xmem_in = '0, opnd_in = '0;
    logic       carry_in = 1'b0;
    logic       res_valid, res_to_mem, carry_out, ovf_out, zero_out, neg_out;
    logic [7:0] res_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] data;
        logic       to_mem;
        logic       c, v, z, n;
        bit         flags_on;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    bcd_addsub_unit u_bcd_addsub_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sub(op_sub),
        .dec_mode(dec_mode), .tmode(tmode), .acc_in(acc_in), .xmem_in(xmem_in),
        .opnd_in(opnd_in), .carry_in(carry_in), .res_valid(res_valid),
        .res_data(res_data), .res_to_mem(res_to_mem), .carry_out(carry_out),
        .ovf_out(ovf_out), .zero_out(zero_out), .neg_out(neg_out)
    );

    function automatic int to_bin(input logic [7:0] v);
        return 10 * int'(v[7:4]) + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] to_bcd(input int v);
        logic [3:0] hi, lo;
        hi = 4'(v / 10);
        lo = 4'(v % 10);
        return {hi, lo};
    endfunction

    function automatic int sgn(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    function automatic exp_t model(input bit sub, input bit dec, input bit t,
                                   input int p, input int q, input bit cin, input string tag);
        exp_t e;
        int   s, sv;
        e.to_mem = t;
        e.tag = tag;
        e.flags_on = !dec;
        if (dec) begin
            if (!sub) begin
                s = to_bin(8'(p)) + to_bin(8'(q)) + int'(cin);
                e.c = (s >= 100);
                e.data = to_bcd(s % 100);
            end else begin
                s = to_bin(8'(p)) - to_bin(8'(q)) - (1 - int'(cin));
                e.c = (s >= 0);
                e.data = to_bcd((s + 100) % 100);
            end
            e.v = 1'b0; e.z = 1'b0; e.n = 1'b0;
        end else begin
            if (!sub) begin
                s  = p + q + int'(cin);
                sv = sgn(p) + sgn(q) + int'(cin);
                e.c = (s > 255);
                e.data = 8'(s % 256);
            end else begin
                s  = p - q - (1 - int'(cin));
                sv = sgn(p) - sgn(q) - (1 - int'(cin));
                e.c = (s >= 0);
                e.data = 8'((s + 256) % 256);
            end
            e.v = (sv > 127) || (sv < -128);
            e.z = (e.data == 8'h00);
            e.n = e.data[7];
        end
        return e;
    endfunction

    task automatic do_op(input bit sub, input bit dec, input bit t, input int p,
                         input int q, input bit cin, input string tag);
        @(negedge clk);
        op_valid = 1'b1;
        op_sub   = sub;
        dec_mode = dec;
        tmode    = t;
        acc_in   = t ? ~8'(p) : 8'(p);
        xmem_in  = t ? 8'(p) : 8'(p) ^ 8'h5A;
        opnd_in  = 8'(q);
        carry_in = cin;
        sb.push_back(model(sub, dec, t, p, q, cin, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid = 1'b0;
            acc_in   = 8'($urandom);
            xmem_in  = 8'($urandom);
            opnd_in  = 8'($urandom);
            carry_in = ~carry_in;
            dec_mode = ~dec_mode;
            op_sub   = ~op_sub;
            tmode    = ~tmode;
        end
    endtask

    task automatic check1(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compare each produced result with the queued expectation
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            exp_t e;
            logic ok;
            if (sb.size() == 0) begin
                check1(1'b0, "R1 unexpected result", 1, 0);
            end else begin
                e = sb.pop_front();
                ok = (res_data === e.data) && (carry_out === e.c) && (res_to_mem === e.to_mem);
                if (e.flags_on)
                    ok = ok && (ovf_out === e.v) && (zero_out === e.z) && (neg_out === e.n);
                check1(ok, e.tag,
                       int'({res_to_mem, carry_out, ovf_out, zero_out, neg_out, res_data}),
                       int'({e.to_mem, e.c, e.v, e.z, e.n, e.data}));
            end
        end
    end

    initial begin
        #(20 * 200000);
        check1(1'b0, "watchdog", 0, 1);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [12:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check1(res_valid == 0 && res_data == 0 && carry_out == 0 && res_to_mem == 0
               && ovf_out == 0 && zero_out == 0 && neg_out == 0, "R1 reset",
               int'({res_valid, res_data}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed corners
        do_op(0, 0, 0, 8'h09, 8'h01, 0, "R10 binary no correction");
        do_op(0, 0, 0, 8'h7F, 8'h01, 0, "R5 R3 pos overflow");
        do_op(0, 0, 1, 8'h80, 8'hFF, 0, "R5 R9 neg overflow");
        do_op(0, 0, 0, 8'h7F, 8'h80, 1, "R5 mixed sign add");
        do_op(1, 0, 0, 8'h80, 8'h01, 1, "R4 R5 sub overflow");
        do_op(1, 0, 1, 8'h00, 8'h00, 0, "R4 R9 borrow wrap");
        do_op(1, 0, 0, 8'h05, 8'h05, 1, "R4 R6 zero");
        do_op(0, 0, 0, 8'hFF, 8'h01, 0, "R3 R6 carry zero");
        do_op(0, 1, 0, 8'h99, 8'h01, 0, "R7 decimal wrap");
        do_op(1, 1, 1, 8'h00, 8'h01, 1, "R8 R9 decimal borrow");
        do_op(0, 1, 0, 8'h09, 8'h01, 0, "R7 R10 decimal digit carry");

        // R2: outputs must stay while idle
        idle(1);
        @(negedge clk);
        held = {res_to_mem, carry_out, ovf_out, zero_out, neg_out, res_data};
        idle(3);
        @(negedge clk);
        check1({res_to_mem, carry_out, ovf_out, zero_out, neg_out, res_data} == held
               && !res_valid, "R2 hold",
               int'({res_to_mem, carry_out, ovf_out, zero_out, neg_out, res_data}), int'(held));

        // binary sweep with both routings
        for (int i = 0; i < 256; i++) begin
            for (int k = 0; k < 4; k++) begin
                do_op(k[1], 0, i[0], i, (i * 37 + 11) % 256, k[0], "R3 R4 R5 R6 R9 binary");
                do_op(k[1], 0, ~i[0], i, i ^ 8'h80, k[0], "R3 R4 R5 R6 R9 binary");
            end
        end

        // exhaustive decimal sweep
        for (int a = 0; a < 100; a++) begin
            for (int b = 0; b < 100; b++) begin
                for (int c = 0; c < 2; c++) begin
                    do_op(0, 1, a[0], to_bcd(a), to_bcd(b), c[0], "R7 R9 decimal add");
                    do_op(1, 1, b[0], to_bcd(a), to_bcd(b), c[0], "R8 R9 decimal sub");
                end
            end
        end

        idle(3);
        check1(sb.size() == 0, "R1 all results seen", sb.size(), 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule